// File: doc/BRIEF.md
# E1 Line Alarm Detector

This block watches the recovered receive bit stream of an E1 line, one bit for each cycle in which the bit-valid strobe is high, and raises three line-level alarms. The first is loss of signal: it is declared on a long run of zeros. It is released only after a measurement window that starts on a received one shows enough ones. The second is the alarm indication signal (AIS): an unframed run of ones whose required length is picked at run time. The third is an auxiliary condition, raised when the line carries a long strictly alternating 1010... pattern.

Each alarm has a registered level flag and a registered one-cycle change pulse. Interrupt logic downstream can latch or mask these pulses. Cycles in which the strobe is low are ignored completely, so the block can sit on a gapped bit clock.

Top module: `e1_line_alarm_det`

## Requirements
- R1: During and after reset, every flag and every change pulse is low.
- R2: Loss of signal is declared on the 128th consecutive received zero. A run of 127 zeros does not declare it. The flag is high in the cycle after the clock edge that accepted the deciding bit.
- R3: While loss of signal is declared, zeros are ignored until a one arrives. That one opens a recovery window of 127 received bits, itself included. If the window holds at least 16 ones, loss of signal clears on the window's last bit.
- R4: A recovery window with 15 or fewer ones leaves loss of signal set. A one on the closing bit of a window counts toward that window. The next window opens on the first one received after the window closes.
- R5: AIS is declared when the current run of ones reaches 512 bits with `ais_long_sel` = 0, or 1024 bits with `ais_long_sel` = 1.
- R6: A received zero clears AIS in the cycle after it is accepted, and restarts the count of the ones run from zero.
- R7: The auxiliary flag is declared when 512 consecutive received bits each differ from the one before. Either starting phase counts.
- R8: Two equal successive bits clear the auxiliary flag. The second of the two begins a new alternating run of length one.
- R9: Cycles with `bit_vld` low change neither the flags nor any count.
- R10: Each change pulse is high for exactly the one cycle in which its flag takes a new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: `rx_bit` holds a new line bit this cycle |
| rx_bit | input | 1 | Recovered receive data bit |
| ais_long_sel | input | 1 | AIS window select: 0 = 512 ones, 1 = 1024 ones |
| los_flag | output | 1 | Loss of signal level |
| ais_flag | output | 1 | Alarm indication signal level |
| aux_flag | output | 1 | Alternating auxiliary pattern level |
| los_chg | output | 1 | One-cycle pulse when `los_flag` changes |
| ais_chg | output | 1 | One-cycle pulse when `ais_flag` changes |
| aux_chg | output | 1 | One-cycle pulse when `aux_flag` changes |

## Verification
Two functions of the loss-of-signal recovery can act on the same bit. When the 127th bit of a recovery window is a one, that bit closes the window and is also a candidate to open the next one. The bench sweeps windows whose ones sit at the start and at the very end, with counts from 14 to 18. It judges that the closing one counts toward the old window, so exactly 16 ones clear the alarm. It then checks that after a failed window, zeros keep the alarm set and a later one opens a fresh window that clears it 127 bits on.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

  typedef struct packed {
    logic flag;
    logic chg;
  } alarm_out_t;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/e1_los_detect.sv
module e1_los_detect
  import e1_alarm_pkg::*;
#(
  parameter int unsigned ZERO_LIMIT = 127,
  parameter int unsigned WIN_LEN    = 127,
  parameter int unsigned MIN_ONES   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       rx_bit,
  output alarm_out_t los_o
);

  localparam int unsigned RUN_W = cnt_w(ZERO_LIMIT + 1);
  localparam int unsigned WIN_W = cnt_w(WIN_LEN);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(ZERO_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_TRIP = RUN_W'(ZERO_LIMIT);
  localparam logic [WIN_W-1:0] POS_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [WIN_W-1:0] ONES_MIN = WIN_W'(MIN_ONES);

  logic [RUN_W-1:0] zero_run_q;
  logic [WIN_W-1:0] pos_q;
  logic [WIN_W-1:0] ones_q;
  logic [WIN_W-1:0] ones_nxt;
  logic             win_act_q;
  logic             los_q;
  logic             chg_q;

  always_comb begin
    ones_nxt = ones_q + {{(WIN_W-1){1'b0}}, rx_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_run_q <= '0;
      pos_q      <= '0;
      ones_q     <= '0;
      win_act_q  <= 1'b0;
      los_q      <= 1'b0;
      chg_q      <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (bit_vld) begin
        if (rx_bit) begin
          zero_run_q <= '0;
        end else if (zero_run_q != RUN_SAT) begin
          zero_run_q <= zero_run_q + 1'b1;
        end

        if (!los_q) begin
          if (!rx_bit && (zero_run_q == RUN_TRIP)) begin
            los_q     <= 1'b1;
            chg_q     <= 1'b1;
            win_act_q <= 1'b0;
          end
        end else if (!win_act_q) begin
          if (rx_bit) begin
            win_act_q <= 1'b1;
            pos_q     <= WIN_W'(1);
            ones_q    <= WIN_W'(1);
          end
        end else if (pos_q == POS_LAST) begin
          win_act_q <= 1'b0;
          if (ones_nxt >= ONES_MIN) begin
            los_q <= 1'b0;
            chg_q <= 1'b1;
          end
        end else begin
          pos_q  <= pos_q + 1'b1;
          ones_q <= ones_nxt;
        end
      end
    end
  end

  assign los_o.flag = los_q;
  assign los_o.chg  = chg_q;

  AST_LOS_SET_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(los_q) |-> ($past(zero_run_q) == RUN_TRIP) && !$past(rx_bit)); // R2
  AST_LOS_CLR_DENSITY: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> $past(win_act_q) && ($past(ones_q) >= ONES_MIN - 1'b1)); // R3
  AST_LOS_WIN_IN_ALARM: assert property (@(posedge clk) disable iff (rst)
    win_act_q |-> los_q); // R4
  AST_LOS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld) |-> $stable(los_q) && $stable(zero_run_q)); // R9

endmodule

// File: rtl/e1_ais_detect.sv
module e1_ais_detect
  import e1_alarm_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 512,
  parameter int unsigned LONG_LEN  = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       rx_bit,
  input  logic       long_sel,
  output alarm_out_t ais_o
);

  localparam int unsigned RUN_W = cnt_w(LONG_LEN);
  localparam logic [RUN_W-1:0] SHORT_T = RUN_W'(SHORT_LEN);
  localparam logic [RUN_W-1:0] LONG_T  = RUN_W'(LONG_LEN);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic [RUN_W-1:0] target;
  logic             ais_q;
  logic             chg_q;

  always_comb begin
    target  = long_sel ? LONG_T : SHORT_T;
    run_nxt = (run_q == LONG_T) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      ais_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (bit_vld) begin
        if (!rx_bit) begin
          run_q <= '0;
          if (ais_q) begin
            ais_q <= 1'b0;
            chg_q <= 1'b1;
          end
        end else begin
          run_q <= run_nxt;
          if (!ais_q && (run_nxt >= target)) begin
            ais_q <= 1'b1;
            chg_q <= 1'b1;
          end
        end
      end
    end
  end

  assign ais_o.flag = ais_q;
  assign ais_o.chg  = chg_q;

  AST_AIS_SET_LONG_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(ais_q) |-> ($past(run_q) >= SHORT_T - 1'b1) && $past(rx_bit)); // R5
  AST_AIS_CLR_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(ais_q) |-> $past(bit_vld) && !$past(rx_bit) && (run_q == '0)); // R6
  AST_AIS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld) |-> $stable(ais_q) && $stable(run_q)); // R9

endmodule

// File: rtl/e1_aux_detect.sv
module e1_aux_detect
  import e1_alarm_pkg::*;
#(
  parameter int unsigned ALT_LEN = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       rx_bit,
  output alarm_out_t aux_o
);

  localparam int unsigned RUN_W = cnt_w(ALT_LEN);
  localparam logic [RUN_W-1:0] RUN_T = RUN_W'(ALT_LEN);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic             prev_q;
  logic             have_prev_q;
  logic             repeat_bit;
  logic             aux_q;
  logic             chg_q;

  always_comb begin
    repeat_bit = have_prev_q && (rx_bit == prev_q);
    run_nxt    = (run_q == RUN_T) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      aux_q       <= 1'b0;
      chg_q       <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (bit_vld) begin
        prev_q      <= rx_bit;
        have_prev_q <= 1'b1;
        if (repeat_bit) begin
          run_q <= RUN_W'(1);
          if (aux_q) begin
            aux_q <= 1'b0;
            chg_q <= 1'b1;
          end
        end else begin
          run_q <= run_nxt;
          if (!aux_q && (run_nxt == RUN_T)) begin
            aux_q <= 1'b1;
            chg_q <= 1'b1;
          end
        end
      end
    end
  end

  assign aux_o.flag = aux_q;
  assign aux_o.chg  = chg_q;

  AST_AUX_SET_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(aux_q) |-> ($past(run_q) == RUN_T - 1'b1)); // R7
  AST_AUX_CLR_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
    $fell(aux_q) |-> $past(bit_vld) && ($past(rx_bit) == $past(prev_q))); // R8
  AST_AUX_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld) |-> $stable(aux_q) && $stable(run_q)); // R9

endmodule

// File: rtl/e1_line_alarm_det.sv
module e1_line_alarm_det
  import e1_alarm_pkg::*;
#(
  parameter int unsigned LOS_ZERO_LIMIT = 127,
  parameter int unsigned LOS_WIN_LEN    = 127,
  parameter int unsigned LOS_MIN_ONES   = 16,
  parameter int unsigned AIS_SHORT_LEN  = 512,
  parameter int unsigned AIS_LONG_LEN   = 1024,
  parameter int unsigned AUX_ALT_LEN    = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic ais_long_sel,
  output logic los_flag,
  output logic ais_flag,
  output logic aux_flag,
  output logic los_chg,
  output logic ais_chg,
  output logic aux_chg
);

  alarm_out_t los_s;
  alarm_out_t ais_s;
  alarm_out_t aux_s;

  e1_los_detect #(
    .ZERO_LIMIT (LOS_ZERO_LIMIT),
    .WIN_LEN    (LOS_WIN_LEN),
    .MIN_ONES   (LOS_MIN_ONES)
  ) u_los (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .rx_bit  (rx_bit),
    .los_o   (los_s)
  );

  e1_ais_detect #(
    .SHORT_LEN (AIS_SHORT_LEN),
    .LONG_LEN  (AIS_LONG_LEN)
  ) u_ais (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .rx_bit   (rx_bit),
    .long_sel (ais_long_sel),
    .ais_o    (ais_s)
  );

  e1_aux_detect #(
    .ALT_LEN (AUX_ALT_LEN)
  ) u_aux (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .rx_bit  (rx_bit),
    .aux_o   (aux_s)
  );

  assign los_flag = los_s.flag;
  assign los_chg  = los_s.chg;
  assign ais_flag = ais_s.flag;
  assign ais_chg  = ais_s.chg;
  assign aux_flag = aux_s.flag;
  assign aux_chg  = aux_s.chg;

  AST_LOS_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
    los_chg == (los_flag != $past(los_flag))); // R10
  AST_AIS_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
    ais_chg == (ais_flag != $past(ais_flag))); // R10
  AST_AUX_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
    aux_chg == (aux_flag != $past(aux_flag))); // R10
  AST_ALARM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ais_flag && aux_flag)); // R5

endmodule

// File: tb/e1_line_alarm_det_test.sv
module e1_line_alarm_det_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic rx_bit = 1'b0;
  logic ais_long_sel = 1'b0;
  logic los_flag, ais_flag, aux_flag, los_chg, ais_chg, aux_chg;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  e1_line_alarm_det uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .ais_long_sel(ais_long_sel),
    .los_flag(los_flag), .ais_flag(ais_flag), .aux_flag(aux_flag),
    .los_chg(los_chg), .ais_chg(ais_chg), .aux_chg(aux_chg)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    rx_bit  = b;
    bit_vld = 1'b1;
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n, input logic b);
    rx_bit  = b;
    bit_vld = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_vld = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic drive_los();
    for (int i = 0; i < 128; i++) send(1'b0);
  endtask

  initial begin
    #1;
    do_reset();
    // R1: reset state
    chk("R1 los", los_flag, 1'b0);
    chk("R1 ais", ais_flag, 1'b0);
    chk("R1 aux", aux_flag, 1'b0);
    chk("R1 chg", los_chg | ais_chg | aux_chg, 1'b0);

    // R2: sweep zero-run lengths around the threshold
    for (int n = 125; n <= 130; n++) begin
      do_reset();
      for (int i = 1; i <= n; i++) begin
        send(1'b0);
        chk("R2 los level", los_flag, i >= 128);
        chk("R10 los pulse", los_chg, i == 128);
      end
    end

    // R3/R4: recovery windows with k ones: first bit and last k-1 bits
    for (int k = 14; k <= 18; k++) begin
      do_reset();
      drive_los();
      for (int i = 0; i < 5; i++) begin
        send(1'b0);
        chk("R3 zeros before window", los_flag, 1'b1);
      end
      for (int j = 0; j < 127; j++) begin
        send((j == 0) || (j >= 127 - (k - 1)));
        if (j < 126) chk("R3 los inside window", los_flag, 1'b1);
      end
      chk("R3 R4 los at window end", los_flag, !(k >= 16));
      chk("R10 los clear pulse", los_chg, k >= 16);
      if (k < 16) begin
        for (int i = 0; i < 3; i++) send(1'b0);
        chk("R4 stays after failed window", los_flag, 1'b1);
        for (int j = 0; j < 127; j++) begin
          send(1'b1);
          if (j == 125) chk("R4 new window not yet closed", los_flag, 1'b1);
        end
        chk("R4 new window clears", los_flag, 1'b0);
      end
    end

    // R5/R6: AIS at both window lengths
    for (int s = 0; s < 2; s++) begin
      int len;
      len = 512 << s;
      do_reset();
      ais_long_sel = logic'(s);
      for (int i = 0; i < len - 1; i++) send(1'b1);
      chk("R5 ais below length", ais_flag, 1'b0);
      send(1'b1);
      chk("R5 ais at length", ais_flag, 1'b1);
      chk("R10 ais set pulse", ais_chg, 1'b1);
      send(1'b1);
      chk("R10 ais pulse one cycle", ais_chg, 1'b0);
      send(1'b0);
      chk("R6 ais clears on zero", ais_flag, 1'b0);
      chk("R10 ais clear pulse", ais_chg, 1'b1);
      for (int i = 0; i < len - 1; i++) send(1'b1);
      send(1'b0);
      for (int i = 0; i < len - 1; i++) send(1'b1);
      chk("R6 run restarted by zero", ais_flag, 1'b0);
      send(1'b1);
      chk("R6 ais after fresh run", ais_flag, 1'b1);
    end
    ais_long_sel = 1'b0;

    // R7/R8: alternating pattern, both phases
    do_reset();
    for (int i = 0; i < 511; i++) send(logic'((i % 2) == 0));
    chk("R7 aux below length", aux_flag, 1'b0);
    send(1'b0);
    chk("R7 aux at 512", aux_flag, 1'b1);
    chk("R10 aux set pulse", aux_chg, 1'b1);
    send(1'b0);
    chk("R8 aux clears on repeat", aux_flag, 1'b0);
    chk("R10 aux clear pulse", aux_chg, 1'b1);
    for (int i = 0; i < 510; i++) send(logic'((i % 2) == 0));
    chk("R8 run restarts at one", aux_flag, 1'b0);
    send(1'b1);
    chk("R7 aux zero-phase run", aux_flag, 1'b1);

    // R9: gaps in bit_vld are ignored
    do_reset();
    for (int i = 0; i < 300; i++) send(1'b1);
    idle(40, 1'b0);
    chk("R9 ais unaffected by idle zeros", ais_flag, 1'b0);
    for (int i = 0; i < 211; i++) send(1'b1);
    chk("R9 ais count held", ais_flag, 1'b0);
    send(1'b1);
    chk("R9 ais at 512 valid ones", ais_flag, 1'b1);
    do_reset();
    for (int i = 0; i < 100; i++) send(1'b0);
    idle(50, 1'b1);
    for (int i = 0; i < 27; i++) send(1'b0);
    chk("R9 los count held", los_flag, 1'b0);
    send(1'b0);
    chk("R9 los after 128 valid zeros", los_flag, 1'b1);
    idle(200, 1'b1);
    chk("R9 los ignores idle ones", los_flag, 1'b1);

    summary();
    $finish;
  end

endmodule